// File: doc/BRIEF.md
# Dual-Bank Mixed-Trigger Interrupt Controller

This block collects 64 interrupt request lines into two banks of 32 bits and drives one registered interrupt line toward a processor. Each bank holds a sticky event register, a mask register and a register that shows the current synchronized state of its inputs. Every bit also has a fixed attribute, set at build time, that marks it as edge-type or level-type.

An edge-type bit latches an event on each rising edge of its synchronized input. The event stays set until software clears it. A level-type bit never latches an event: its live level drives the request directly, and software clears leave it alone. Software reaches the registers through a single-cycle port with a byte address. Read data arrives one cycle after the request.

The banks are filled in reverse order. The low 32 inputs feed the bank at the higher register address.

Top module: `dual_bank_irq_ctrl`

## Requirements
- R1: Input `irq_in[n]` with n < 32 maps to bit n of the bank at base 0x20. Input n ≥ 32 maps to bit n−32 of the bank at base 0x10.
- R2: The level register (bank offset 0xC) shows each input through a 2-stage synchronizer. A change on `irq_in` appears there after the third rising clock edge.
- R3: An edge-type bit sets its event bit (offset 0x0) exactly once per low-to-high transition of the synchronized input. The event bit stays set after the input falls and while it stays high.
- R4: Bits 20 to 28 of the bank at 0x20 are level-type, and every other bit is edge-type. A level-type bit never sets its event bit.
- R5: A write to offset 0x8 clears each edge-type event bit whose written bit is 1. Written 0 bits and level-type bits are left unchanged.
- R6: If an event bit is set and cleared on the same clock edge, it ends up set.
- R7: Offset 0x4 is a read/write mask register. A masked-off bit (mask 0) cannot raise `cpu_irq`, although its event bit still latches.
- R8: `cpu_irq` is the OR over both banks of ((events | (levels & level_type)) & mask). It is registered and follows a change of that term one cycle later.
- R9: The bank index is (addr − 0x10) >> 4, using 12-bit wrap-around. An index of 2 or more ignores writes and reads as zero. Offset 0x8, and any offset other than 0x0, 0x4 and 0xC, reads as zero.
- R10: Synchronous reset clears events, masks, levels, synchronizers, `rdata` and `cpu_irq`.
- R11: A read (`req`=1, `we`=0) returns the register contents from before that edge on `rdata` one cycle later. `rdata` holds its value when there is no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 64 | Asynchronous interrupt request lines |
| req | input | 1 | Register access strobe |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after a read |
| cpu_irq | output | 1 | Registered interrupt request to the processor |

## Verification
Single pulses on one input in each bank show the reversed bank order and the sticky edge latch. A held-high input, cleared while still high, shows that an event fires only once per rising edge. A hard-wired level-type input, hit with an all-ones clear, shows that the request follows the live level and cannot be cleared by software. A clear timed onto the same edge as a new event shows which one wins. Long random runs of input toggles mixed with reads, writes and out-of-range addresses are compared every cycle against a behavioural model; they bring out latency and masking mismatches that the directed cases may miss.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned REG_OFS_W = 4;

  localparam logic [REG_OFS_W-1:0] OFS_EVENTS = 4'h0;
  localparam logic [REG_OFS_W-1:0] OFS_MASK   = 4'h4;
  localparam logic [REG_OFS_W-1:0] OFS_CLEAR  = 4'h8;
  localparam logic [REG_OFS_W-1:0] OFS_LEVELS = 4'hC;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_EVENTS,
    SEL_MASK,
    SEL_CLEAR,
    SEL_LEVELS
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [REG_OFS_W-1:0] ofs);
    reg_sel_e sel;
    case (ofs)
      OFS_EVENTS: sel = SEL_EVENTS;
      OFS_MASK:   sel = SEL_MASK;
      OFS_CLEAR:  sel = SEL_CLEAR;
      OFS_LEVELS: sel = SEL_LEVELS;
      default:    sel = SEL_NONE;
    endcase
    return sel;
  endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned W      = 64,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [STAGES-1:0][W-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= '0;
        else     chain_q[0] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain_q[s] <= '0;
        else     chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
  parameter int unsigned   W        = 32,
  parameter logic [W-1:0]  LVL_ATTR = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sync_lvl,
  input  logic         mask_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] events,
  output logic [W-1:0] mask,
  output logic [W-1:0] levels,
  output logic         bank_req
);

  logic [W-1:0] events_q, mask_q, levels_q;
  logic [W-1:0] rise, set_bits, clr_bits;

  // rising edge of the synchronized input against the held level
  assign rise     = sync_lvl & ~levels_q;
  assign set_bits = rise & ~LVL_ATTR;
  assign clr_bits = clr_we ? (wdata & ~LVL_ATTR) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      events_q <= '0;
      mask_q   <= '0;
      levels_q <= '0;
    end else begin
      levels_q <= sync_lvl;
      // new event has priority over a same-cycle clear
      events_q <= (events_q & ~clr_bits) | set_bits;
      if (mask_we) mask_q <= wdata;
    end
  end

  assign bank_req = |((events_q | (levels_q & LVL_ATTR)) & mask_q);
  assign events   = events_q;
  assign mask     = mask_q;
  assign levels   = levels_q;

endmodule

// File: rtl/irqc_regport.sv
module irqc_regport
  import irqc_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NBANK  = 2,
  parameter int unsigned BASE   = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [NBANK-1:0][DATA_W-1:0]  ev,
  input  logic [NBANK-1:0][DATA_W-1:0]  mk,
  input  logic [NBANK-1:0][DATA_W-1:0]  lv,
  output logic [NBANK-1:0]              mask_we,
  output logic [NBANK-1:0]              clr_we,
  output logic [DATA_W-1:0]             rdata
);

  localparam int unsigned IDX_W  = ADDR_W - REG_OFS_W;
  localparam int unsigned BSEL_W = (NBANK > 1) ? $clog2(NBANK) : 1;

  logic [ADDR_W-1:0]    rel;
  logic [IDX_W-1:0]     idx;
  logic [REG_OFS_W-1:0] ofs;
  logic [BSEL_W-1:0]    bank_sel;
  logic                 bank_ok;
  reg_sel_e             sel;
  logic [DATA_W-1:0]    rd_next;
  logic [DATA_W-1:0]    rdata_q;

  assign rel      = addr - ADDR_W'(BASE);
  assign idx      = rel[ADDR_W-1:REG_OFS_W];
  assign ofs      = rel[REG_OFS_W-1:0];
  assign bank_ok  = (idx < IDX_W'(NBANK));
  assign bank_sel = idx[BSEL_W-1:0];
  assign sel      = decode_offset(ofs);

  for (genvar b = 0; b < NBANK; b++) begin : g_we
    assign mask_we[b] = req && we && bank_ok && (idx == IDX_W'(b)) && (sel == SEL_MASK);
    assign clr_we[b]  = req && we && bank_ok && (idx == IDX_W'(b)) && (sel == SEL_CLEAR);
  end

  always_comb begin
    rd_next = '0;
    if (bank_ok) begin
      case (sel)
        SEL_EVENTS: rd_next = ev[bank_sel];
        SEL_MASK:   rd_next = mk[bank_sel];
        SEL_LEVELS: rd_next = lv[bank_sel];
        default:    rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             rdata_q <= '0;
    else if (req && !we) rdata_q <= rd_next;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/dual_bank_irq_ctrl.sv
module dual_bank_irq_ctrl #(
  parameter int unsigned NBANK       = 2,
  parameter int unsigned BANK_W      = 32,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BANK_BASE   = 16,
  parameter logic [NBANK-1:0][BANK_W-1:0] LVL_ATTR = {32'h1FF0_0000, 32'h0000_0000}
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NBANK*BANK_W-1:0]   irq_in,
  input  logic                      req,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [BANK_W-1:0]         wdata,
  output logic [BANK_W-1:0]         rdata,
  output logic                      cpu_irq
);

  localparam int unsigned NIRQ = NBANK * BANK_W;

  logic [NIRQ-1:0]                 irq_sync;
  logic [NBANK-1:0][BANK_W-1:0]    ev_all, mk_all, lv_all;
  logic [NBANK-1:0]                mask_we, clr_we, bank_req;
  logic                            cpu_irq_q;

  irqc_sync #(.W(NIRQ), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (irq_in),
    .sync_out (irq_sync)
  );

  // reversed bank order: input group g lands in bank NBANK-1-g
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int unsigned GRP = NBANK - 1 - b;
    irqc_bank #(.W(BANK_W), .LVL_ATTR(LVL_ATTR[b])) u_bank (
      .clk      (clk),
      .rst      (rst),
      .sync_lvl (irq_sync[GRP*BANK_W +: BANK_W]),
      .mask_we  (mask_we[b]),
      .clr_we   (clr_we[b]),
      .wdata    (wdata),
      .events   (ev_all[b]),
      .mask     (mk_all[b]),
      .levels   (lv_all[b]),
      .bank_req (bank_req[b])
    );
  end

  irqc_regport #(
    .ADDR_W (ADDR_W),
    .DATA_W (BANK_W),
    .NBANK  (NBANK),
    .BASE   (BANK_BASE)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .we      (we),
    .addr    (addr),
    .ev      (ev_all),
    .mk      (mk_all),
    .lv      (lv_all),
    .mask_we (mask_we),
    .clr_we  (clr_we),
    .rdata   (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) cpu_irq_q <= 1'b0;
    else     cpu_irq_q <= |bank_req;
  end

  assign cpu_irq = cpu_irq_q;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int unsigned NBANK     = 2,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BANK_BASE = 16,
  parameter logic [NBANK-1:0][BANK_W-1:0] LVL_ATTR = {32'h1FF0_0000, 32'h0000_0000}
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         req,
  input logic                         we,
  input logic [ADDR_W-1:0]            addr,
  input logic [BANK_W-1:0]            wdata,
  input logic [BANK_W-1:0]            rdata,
  input logic                         cpu_irq,
  input logic [NBANK-1:0][BANK_W-1:0] ev,
  input logic [NBANK-1:0][BANK_W-1:0] mk,
  input logic [NBANK-1:0][BANK_W-1:0] lv
);

  logic any_req;
  logic lvl_evt_seen;
  always_comb begin
    any_req      = 1'b0;
    lvl_evt_seen = 1'b0;
    for (int b = 0; b < NBANK; b++) begin
      any_req      = any_req | (|((ev[b] | (lv[b] & LVL_ATTR[b])) & mk[b]));
      lvl_evt_seen = lvl_evt_seen | (|(ev[b] & LVL_ATTR[b]));
    end
  end

  assert_reset_R10: assert property (@(posedge clk)
    rst |=> (cpu_irq == 1'b0 && ev == '0 && mk == '0 && lv == '0 && rdata == '0));

  assert_combine_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cpu_irq == $past(any_req)));

  assert_level_no_event_R4: assert property (@(posedge clk) disable iff (rst)
    !lvl_evt_seen);

  assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    !(req && we) |=> ((ev & $past(ev)) == $past(ev)));

  assert_clear_all_R5: assert property (@(posedge clk) disable iff (rst)
    (req && we && addr == ADDR_W'(BANK_BASE + 8) && wdata == '1)
      |=> (ev[0] == (lv[0] & ~$past(lv[0]) & ~LVL_ATTR[0])));

  assert_mask_write_R7: assert property (@(posedge clk) disable iff (rst)
    (req && we && addr == ADDR_W'(BANK_BASE + 4)) |=> (mk[0] == $past(wdata)));

  assert_oob_read_R9: assert property (@(posedge clk) disable iff (rst)
    (req && !we && (addr < ADDR_W'(BANK_BASE) || addr >= ADDR_W'(BANK_BASE + NBANK*16)))
      |=> (rdata == '0));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !(req && !we) |=> $stable(rdata));

endmodule

bind dual_bank_irq_ctrl irqc_checker #(
  .NBANK     (NBANK),
  .BANK_W    (BANK_W),
  .ADDR_W    (ADDR_W),
  .BANK_BASE (BANK_BASE),
  .LVL_ATTR  (LVL_ATTR)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .req     (req),
  .we      (we),
  .addr    (addr),
  .wdata   (wdata),
  .rdata   (rdata),
  .cpu_irq (cpu_irq),
  .ev      (ev_all),
  .mk      (mk_all),
  .lv      (lv_all)
);

// File: tb/dual_bank_irq_ctrl_tb.sv
`timescale 1ns/1ps
module dual_bank_irq_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] irq_in;
  logic        req, we;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        cpu_irq;

  always #2.5 clk = ~clk;

  dual_bank_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .req(req), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata), .cpu_irq(cpu_irq)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  localparam logic [31:0] LVL [2] = '{32'h0000_0000, 32'h1FF0_0000};
  logic [31:0] m_ev [2];
  logic [31:0] m_mk [2];
  logic [31:0] m_lv [2];
  logic [31:0] n_lv [2];
  logic        m_irq;
  logic [31:0] m_rd;
  logic        rd_due;
  logic [63:0] hist [$];
  logic [63:0] dropped;

  function automatic logic [31:0] model_read(input logic [11:0] a);
    int rel;
    int bk;
    rel = int'(a) - 16;
    if (rel < 0 || rel >= 32) return 32'h0;
    bk = rel / 16;
    case (a[3:0])
      4'h0: return m_ev[bk];
      4'h4: return m_mk[bk];
      4'hC: return m_lv[bk];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 2; b++) begin
        m_ev[b] = '0; m_mk[b] = '0; m_lv[b] = '0;
      end
      hist   = {64'h0, 64'h0, 64'h0};
      m_irq  = 1'b0;
      m_rd   = '0;
      rd_due = 1'b0;
    end else begin
      hist.push_back(irq_in);
      dropped = hist.pop_front();
      n_lv[0] = hist[0][63:32];
      n_lv[1] = hist[0][31:0];
      rd_due  = req && !we;
      if (rd_due) m_rd = model_read(addr);
      m_irq = 1'b0;
      for (int b = 0; b < 2; b++)
        if (((m_ev[b] | (m_lv[b] & LVL[b])) & m_mk[b]) != 0) m_irq = 1'b1;
      for (int b = 0; b < 2; b++) begin
        logic [31:0] clr;
        int rel;
        clr = '0;
        rel = int'(addr) - 16;
        if (req && we && rel >= 0 && rel < 32 && (rel / 16) == b) begin
          if (addr[3:0] == 4'h4) m_mk[b] = wdata;
          if (addr[3:0] == 4'h8) clr = wdata & ~LVL[b];
        end
        m_ev[b] = (m_ev[b] & ~clr) | (n_lv[b] & ~m_lv[b] & ~LVL[b]);
        m_lv[b] = n_lv[b];
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R8 cpu_irq vs model", {31'h0, cpu_irq}, {31'h0, m_irq});
      if (rd_due) check("R11 rdata vs model", rdata, m_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input string tag, input logic [31:0] exp);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    check(tag, rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; irq_in = '0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    idle(4);
    check("R10 cpu_irq in reset", {31'h0, cpu_irq}, 32'h0);
    check("R10 rdata in reset", rdata, 32'h0);
    rst = 1'b0;
    rd(12'h014, "R10 mask bank0", 32'h0);
    rd(12'h020, "R10 events bank1", 32'h0);
    rd(12'h02C, "R10 levels bank1", 32'h0);

    // R7 mask read/write
    wr(12'h014, 32'hFFFF_FFFF);
    wr(12'h024, 32'hFFFF_FFFF);
    rd(12'h014, "R7 mask bank0", 32'hFFFF_FFFF);
    rd(12'h024, "R7 mask bank1", 32'hFFFF_FFFF);

    // R1/R2/R3: input 40 -> bank0 bit 8
    @(negedge clk); irq_in[40] = 1'b1;
    idle(2);
    check("R2 level not yet visible", {31'h0, cpu_irq}, 32'h0);
    idle(4);
    rd(12'h01C, "R2 levels bank0", 32'h0000_0100);
    rd(12'h010, "R1 events bank0", 32'h0000_0100);
    rd(12'h020, "R1 events bank1 untouched", 32'h0);
    check("R8 irq from edge event", {31'h0, cpu_irq}, 32'h1);
    irq_in[40] = 1'b0;
    idle(5);
    rd(12'h01C, "R2 levels bank0 low", 32'h0);
    rd(12'h010, "R3 event sticky after fall", 32'h0000_0100);

    // R5 clear
    wr(12'h018, 32'h0000_0100);
    idle(2);
    rd(12'h010, "R5 event cleared", 32'h0);
    check("R8 irq drops after clear", {31'h0, cpu_irq}, 32'h0);

    // R1 low input to bank1, R5 zero write, R3 held high
    @(negedge clk); irq_in[3] = 1'b1;
    idle(6);
    rd(12'h020, "R1 input 3 in bank1", 32'h0000_0008);
    wr(12'h028, 32'h0);
    rd(12'h020, "R5 zero clear no effect", 32'h0000_0008);
    wr(12'h028, 32'h0000_0008);
    idle(6);
    rd(12'h020, "R3 held high no re-latch", 32'h0);
    rd(12'h02C, "R2 held level visible", 32'h0000_0008);
    check("R8 no irq for held edge input", {31'h0, cpu_irq}, 32'h0);
    irq_in[3] = 1'b0;
    idle(5);

    // R4 level-type input 22
    @(negedge clk); irq_in[22] = 1'b1;
    idle(6);
    rd(12'h02C, "R4 level bit visible", 32'h0040_0000);
    rd(12'h020, "R4 no event for level bit", 32'h0);
    check("R4 irq from level", {31'h0, cpu_irq}, 32'h1);
    wr(12'h028, 32'hFFFF_FFFF);
    idle(2);
    check("R5 level immune to clear", {31'h0, cpu_irq}, 32'h1);
    irq_in[22] = 1'b0;
    idle(6);
    check("R8 irq follows level low", {31'h0, cpu_irq}, 32'h0);

    // R7 masking, input 50 -> bank0 bit 18
    wr(12'h014, 32'h0);
    @(negedge clk); irq_in[50] = 1'b1;
    idle(6);
    rd(12'h010, "R7 event latches while masked", 32'h0004_0000);
    check("R7 masked no irq", {31'h0, cpu_irq}, 32'h0);
    wr(12'h014, 32'h0004_0000);
    idle(2);
    check("R8 irq after unmask", {31'h0, cpu_irq}, 32'h1);
    irq_in[50] = 1'b0;
    wr(12'h018, 32'h0004_0000);
    idle(6);
    wr(12'h014, 32'hFFFF_FFFF);

    // R6 same-edge set and clear, input 9 -> bank1 bit 9
    @(negedge clk); irq_in[9] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 12'h028; wdata = 32'h0000_0200;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    idle(2);
    rd(12'h020, "R6 set wins over clear", 32'h0000_0200);
    irq_in[9] = 1'b0;
    wr(12'h028, 32'h0000_0200);
    idle(5);

    // R9 address decode, input 33 -> bank0 bit 1
    @(negedge clk); irq_in[33] = 1'b1;
    idle(6);
    wr(12'h034, 32'h0);
    wr(12'h004, 32'h0);
    rd(12'h014, "R9 out-of-range write ignored", 32'hFFFF_FFFF);
    rd(12'h034, "R9 bank index 2 reads zero", 32'h0);
    rd(12'h000, "R9 below base reads zero", 32'h0);
    rd(12'h110, "R9 far index reads zero", 32'h0);
    rd(12'h018, "R9 clear offset reads zero", 32'h0);
    rd(12'h012, "R9 odd offset reads zero", 32'h0);
    rd(12'h010, "R1 input 33 in bank0", 32'h0000_0002);
    irq_in[33] = 1'b0;
    wr(12'h018, 32'h0000_0002);
    idle(5);

    // random mix compared against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom % 3 == 0) begin
        int k;
        k = int'($urandom % 64);
        irq_in[k] = ~irq_in[k];
      end
      req = ($urandom % 3 == 0);
      we  = ($urandom % 2 == 0);
      case ($urandom % 10)
        0: addr = 12'h010; 1: addr = 12'h014; 2: addr = 12'h018; 3: addr = 12'h01C;
        4: addr = 12'h020; 5: addr = 12'h024; 6: addr = 12'h028; 7: addr = 12'h02C;
        8: addr = 12'h030; default: addr = 12'h008;
      endcase
      wdata = $urandom;
    end
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    idle(4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule